// File: doc/BRIEF.md
# Parallel EEPROM Write and Poll Sequencer

This block sits on the host side of an asynchronous byte-wide EEPROM. It takes one command at a time from a valid/ready interface. A command is a read or a write, with an 11-bit address and, for a write, a data byte. The block then drives the memory's chip enable, output enable and write enable strobes, the address bus and the data bus.

Every memory timing interval is given in nanoseconds as a parameter. Each interval is rounded up to whole cycles of the block clock, using a clock-period parameter. This covers address setup and hold, write pulse width, data setup and hold, output-enable setup and hold around the write pulse, the busy-indication delay and read access time.

A write is not reported finished until the memory's internal programming has ended. A mode input picks how that is detected:
- Data polling reads the same address repeatedly until bit 7 matches the written bit 7.
- Ready/busy mode samples an open-drain ready line through a two-flop synchronizer.

Both methods are bounded by a timeout. When the timeout expires first, the response carries an error flag. Each command ends with a one-cycle response pulse that carries read data and the error flag.

Top module: `eew_seq`

## Requirements
- R1: `cmd_ready` is high only while the block is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low in the cycle after it is taken. While idle, all three strobes are high.
- R2: In a write, chip enable is low, output enable is high and the data bus is driven, all with the address already stable, for at least ceil(max(address setup, OE setup)/clock period) cycles before write enable falls.
- R3: Write enable stays low for at least ceil(max(write pulse, data setup, address hold)/clock period) cycles. Address and driven data stay stable throughout this time.
- R4: After write enable rises, data and address stay driven and output enable stays high for ceil(max(data hold, OE hold, busy delay)/clock period) cycles before any poll read. In ready/busy mode this phase is two cycles longer.
- R5: In polling mode (`mode_poll`=1), the block reads the written address with CE and OE low. A read whose bit 7 equals the written bit 7 ends the write without error. A complemented bit 7 causes another read after one cycle with OE high.
- R6: In ready/busy mode (`mode_poll`=0), the write ends without error on the first cycle in which the synchronized `mem_rdy` is 1. A 1 on `mem_rdy` means ready.
- R7: The completion wait is bounded by ceil(timeout/clock period) cycles. In ready/busy mode, completion seen in the last wait cycle still succeeds. If completion is not seen in that cycle, the response has `rsp_error`=1. In polling mode, the limit is judged at the end of each poll read.
- R8: A read holds CE and OE low with the address stable for ceil(max(address access, OE access)/clock period) cycles. The byte is captured on the last of those cycles and returned on `rsp_rdata` with `rsp_error`=0.
- R9: `rsp_valid` is a one-cycle pulse. In reset, all strobes are high, `mem_dq_oe` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R10: The data bus is never driven while output enable is low, and write enable is low only while chip enable is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 11 | Byte address |
| cmd_wdata | input | 8 | Byte to write |
| mode_poll | input | 1 | 1 = data polling, 0 = ready/busy line |
| rsp_valid | output | 1 | One-cycle command completion pulse |
| rsp_rdata | output | 8 | Read byte (0 after a write) |
| rsp_error | output | 1 | Completion wait timed out |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 11 | Memory address bus |
| mem_dq_out | output | 8 | Data bus value to drive |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Data bus value read back |
| mem_rdy | input | 1 | Ready/busy line, 1 = ready |

## Verification
Completion detection and timeout expiry can fall in the same cycle of the ready/busy wait. When they do, completion wins. The bench provokes this by releasing the ready line at a counted number of cycles after write enable rises. It picks the count so that the synchronized ready is first seen exactly in the final wait cycle, and expects a clean response. It then repeats the write with the release one cycle later and expects the error response in the same cycle.

// File: rtl/eew_pkg.sv
// Shared types and timing helpers for the EEPROM write/poll sequencer.
// Assumes all timing parameters are non-negative nanosecond values.
package eew_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPULSE,
        ST_WHOLD,
        ST_PREAD,
        ST_PGAP,
        ST_RWAIT,
        ST_RACC,
        ST_RESP
    } seq_st_e;

    // Round a nanosecond interval up to whole clock cycles, at least one
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    // Larger of two values
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eew_sync.sv
// Multi-flop synchronizer for an asynchronous level input.
// Assumes the input changes slowly compared with the clock.
module eew_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/eew_timer.sv
// Loadable down counter with a zero flag; loading has priority over counting.
// Assumes the count stops at zero when no load arrives.
module eew_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load, or count down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/eew_seq.sv
// Host-side sequencer for byte reads and writes on an asynchronous EEPROM bus.
// It turns nanosecond strobe timing into cycle counts and, after a write,
// waits for completion by bit-7 polling or by a synchronized ready line,
// bounded by a timeout. One command is handled at a time.
// Assumes mem_dq_in is stable whenever output enable has been low for the access time.
module eew_seq #(
    parameter int unsigned ADDR_W  = 11,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned AS_NS   = 10,
    parameter int unsigned AH_NS   = 50,
    parameter int unsigned WP_NS   = 100,
    parameter int unsigned DS_NS   = 50,
    parameter int unsigned DH_NS   = 10,
    parameter int unsigned OES_NS  = 10,
    parameter int unsigned OEH_NS  = 10,
    parameter int unsigned BUSY_NS = 50,
    parameter int unsigned ACC_NS  = 150,
    parameter int unsigned OEA_NS  = 80,
    parameter int unsigned TO_NS   = 1_100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              mode_poll,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    input  logic              mem_rdy
);
    import eew_pkg::*;

    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned SET_CYC  = cyc_of(max2(AS_NS, OES_NS), CLK_NS);
    localparam int unsigned PW_CYC   = cyc_of(max2(WP_NS, max2(DS_NS, AH_NS)), CLK_NS);
    localparam int unsigned HOLD_CYC = cyc_of(max2(DH_NS, max2(OEH_NS, BUSY_NS)), CLK_NS);
    localparam int unsigned ACC_CYC  = cyc_of(max2(ACC_NS, OEA_NS), CLK_NS);
    localparam int unsigned TO_CYC   = cyc_of(TO_NS, CLK_NS);
    localparam int unsigned PH_MAX   = max2(max2(SET_CYC, PW_CYC),
                                            max2(HOLD_CYC + SYNC_STAGES, ACC_CYC));
    localparam int unsigned PH_W     = $clog2(PH_MAX + 1);
    localparam int unsigned TO_W     = $clog2(TO_CYC + 1);

    seq_st_e           st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, rdata_q;
    logic              poll_q, err_q;
    logic              ph_load, ph_zero, to_load, to_dec, to_zero, rdy_s;
    logic [PH_W-1:0]   ph_val;
    logic              bit_match;

    eew_sync #(.STAGES(SYNC_STAGES)) rdy_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(mem_rdy), .sync_out(rdy_s)
    );

    eew_timer #(.W(PH_W)) phase_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
        .dec(1'b1), .zero(ph_zero)
    );

    eew_timer #(.W(TO_W)) limit_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(to_load), .load_val(TO_W'(TO_CYC - 1)),
        .dec(to_dec), .zero(to_zero)
    );

    assign bit_match = (mem_dq_in[DATA_W-1] == data_q[DATA_W-1]);
    assign to_dec    = (st_q inside {ST_PREAD, ST_PGAP, ST_RWAIT});

    // Next-state and phase-timer selection
    always_comb begin
        st_d    = st_q;
        ph_load = 1'b0;
        ph_val  = '0;
        to_load = 1'b0;
        unique case (st_q)
            ST_IDLE: if (cmd_valid) begin
                ph_load = 1'b1;
                if (cmd_write) begin
                    st_d   = ST_WSET;
                    ph_val = PH_W'(SET_CYC - 1);
                end else begin
                    st_d   = ST_RACC;
                    ph_val = PH_W'(ACC_CYC - 1);
                end
            end
            ST_WSET: if (ph_zero) begin
                st_d    = ST_WPULSE;
                ph_load = 1'b1;
                ph_val  = PH_W'(PW_CYC - 1);
            end
            ST_WPULSE: if (ph_zero) begin
                st_d    = ST_WHOLD;
                ph_load = 1'b1;
                ph_val  = poll_q ? PH_W'(HOLD_CYC - 1)
                                 : PH_W'(HOLD_CYC + SYNC_STAGES - 1);
            end
            ST_WHOLD: if (ph_zero) begin
                to_load = 1'b1;
                if (poll_q) begin
                    st_d    = ST_PREAD;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(ACC_CYC - 1);
                end else begin
                    st_d = ST_RWAIT;
                end
            end
            ST_PREAD: if (ph_zero) begin
                if (bit_match || to_zero) st_d = ST_RESP;
                else                      st_d = ST_PGAP;
            end
            ST_PGAP: begin
                st_d    = ST_PREAD;
                ph_load = 1'b1;
                ph_val  = PH_W'(ACC_CYC - 1);
            end
            ST_RWAIT: if (rdy_s || to_zero) st_d = ST_RESP;
            ST_RACC:  if (ph_zero) st_d = ST_RESP;
            ST_RESP:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Command capture, read-data capture and timeout flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            poll_q  <= 1'b0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (st_q == ST_IDLE && cmd_valid) begin
            addr_q  <= cmd_addr;
            data_q  <= cmd_write ? cmd_wdata : '0;
            poll_q  <= mode_poll;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (st_q == ST_RACC && ph_zero) begin
            rdata_q <= mem_dq_in;
        end else if (st_q == ST_PREAD && ph_zero && !bit_match && to_zero) begin
            err_q   <= 1'b1;
        end else if (st_q == ST_RWAIT && !rdy_s && to_zero) begin
            err_q   <= 1'b1;
        end
    end

    assign cmd_ready  = (st_q == ST_IDLE);
    assign rsp_valid  = (st_q == ST_RESP);
    assign rsp_rdata  = rdata_q;
    assign rsp_error  = err_q;
    assign mem_ce_n   = !(st_q inside {ST_WSET, ST_WPULSE, ST_WHOLD, ST_PREAD, ST_PGAP, ST_RACC});
    assign mem_oe_n   = !(st_q inside {ST_PREAD, ST_RACC});
    assign mem_we_n   = !(st_q == ST_WPULSE);
    assign mem_dq_oe  = (st_q inside {ST_WSET, ST_WPULSE, ST_WHOLD});
    assign mem_addr   = addr_q;
    assign mem_dq_out = data_q;
endmodule

// File: rtl/eew_seq_chk.sv
// Property checker for the EEPROM sequencer, bound to every instance of eew_seq.
// Assumes PW_CYC matches the instance's write pulse length in cycles.
module eew_seq_chk #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned PW_CYC = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              rsp_error,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);
    logic [15:0] we_low_q;

    // Count consecutive cycles with write enable low
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_q <= '0;
        else if (!mem_we_n) we_low_q <= (we_low_q == 16'hFFFF) ? we_low_q : we_low_q + 16'd1;
        else                we_low_q <= '0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R2
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n && mem_oe_n && mem_dq_oe) && $stable(mem_addr)));

    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_q >= 16'(PW_CYC)));

    // R3
    we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    // R4
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> (mem_oe_n && mem_dq_oe && $stable(mem_addr)));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> rsp_valid || !$past(rsp_valid) || cmd_ready);

    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R10
    we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));
endmodule

bind eew_seq eew_seq_chk #(.ADDR_W(ADDR_W), .PW_CYC(PW_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_error(rsp_error), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/eew_seq_tb.sv
module eew_seq_tb_top;
    localparam int CLK_PERIOD_NS = 10;
    localparam int TO_NS_TB  = 3000;
    // Expected cycle counts from the requirements at a 10 ns clock
    localparam int SET_C  = 1;    // ceil(max(10,10)/10)
    localparam int PW_C   = 10;   // ceil(max(100,50,50)/10)
    localparam int HOLD_C = 5;    // ceil(max(10,10,50)/10)
    localparam int ACC_C  = 15;   // ceil(max(150,80)/10)
    localparam int TO_C   = 300;  // ceil(3000/10)
    localparam int H_RDY  = HOLD_C + 2;

    typedef struct packed {
        logic        wr;
        logic        poll;
        logic [10:0] addr;
        logic [7:0]  data;
        logic [15:0] busy;
        logic        err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 1'b1, 11'h005, 8'hA5, 16'd40,   1'b0},
        '{1'b0, 1'b0, 11'h005, 8'hA5, 16'd0,    1'b0},
        '{1'b1, 1'b1, 11'h7FF, 8'h3C, 16'd120,  1'b0},
        '{1'b0, 1'b0, 11'h7FF, 8'h3C, 16'd0,    1'b0},
        '{1'b1, 1'b1, 11'h010, 8'h7E, 16'd1,    1'b0},
        '{1'b1, 1'b0, 11'h000, 8'h81, 16'd60,   1'b0},
        '{1'b0, 1'b0, 11'h000, 8'h81, 16'd0,    1'b0},
        '{1'b1, 1'b1, 11'h123, 8'h5A, 16'd2000, 1'b1},
        '{1'b1, 1'b0, 11'h124, 8'h66, 16'd2000, 1'b1},
        '{1'b0, 1'b0, 11'h123, 8'h5A, 16'd0,    1'b0},
        '{1'b0, 1'b0, 11'h124, 8'h66, 16'd0,    1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, mode_poll = 1'b1;
    logic [10:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        cmd_ready, rsp_valid, rsp_error;
    logic [7:0]  rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_rdy;
    logic [10:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0, failures = 0, cycles = 0;
    int busy_len = 0;
    logic force_en = 1'b0, force_val = 1'b0;

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    eew_seq #(.CLK_NS(CLK_PERIOD_NS), .TO_NS(TO_NS_TB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .mode_poll(mode_poll), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_error(rsp_error), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_rdy(mem_rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model, updated away from the active edge
    logic [7:0] mem [0:2047];
    logic [7:0] last_wr = '0;
    int  busy_q = 0;
    logic we_prev = 1'b1;
    assign mem_rdy = force_en ? force_val : (busy_q == 0);

    always @(negedge clk) begin
        we_prev <= mem_we_n;
        if (!we_prev && mem_we_n) begin
            mem[mem_addr] <= mem_dq_out;
            last_wr       <= mem_dq_out;
            busy_q        <= busy_len;
        end else if (busy_q > 0) begin
            busy_q <= busy_q - 1;
        end
        if (!mem_ce_n && !mem_oe_n)
            mem_dq_in <= (busy_q > 0) ? {~last_wr[7], last_wr[6:0]} : mem[mem_addr];
        else
            mem_dq_in <= 8'h00;
    end

    // Strobe timing monitor (R2, R3, R4, R8)
    int setup_run = 0, we_run = 0, oe_run = 0, since_rise = -1;
    logic we_m = 1'b1, oe_m = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (we_m && !mem_we_n)
                chk(setup_run >= SET_C && mem_oe_n, "R2 setup before WE fall", setup_run, SET_C);
            if (!we_m && mem_we_n) begin
                chk(we_run >= PW_C, "R3 WE low width", we_run, PW_C);
                since_rise = 0;
            end else if (since_rise >= 0) begin
                since_rise = since_rise + 1;
            end
            if (oe_m && !mem_oe_n && since_rise >= 0) begin
                chk(since_rise >= HOLD_C, "R4 hold before poll read", since_rise, HOLD_C);
                since_rise = -1;
            end
            if (!oe_m && mem_oe_n) begin
                chk(oe_run >= ACC_C, "R8 OE low width", oe_run, ACC_C);
            end
            if (cmd_ready) since_rise = -1;
        end
        setup_run = (!mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe) ? setup_run + 1 : 0;
        we_run    = !mem_we_n ? we_run + 1 : 0;
        oe_run    = !mem_oe_n ? oe_run + 1 : 0;
        we_m = mem_we_n;
        oe_m = mem_oe_n;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic launch(input logic wr, input logic poll, input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; mode_poll = poll; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R1 ready low after accept", cmd_ready, 0);
    endtask

    task automatic wait_rsp(output logic [7:0] rd, output logic er, output bit got);
        got = 0; rd = '0; er = 1'b0;
        for (int i = 0; i < 6000 && !got; i++) begin
            if (rsp_valid) begin got = 1; rd = rsp_rdata; er = rsp_error; end
            else @(negedge clk);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 response one cycle", rsp_valid, 0);
    endtask

    task automatic wait_idle_mem();
        for (int i = 0; i < 6000 && busy_q != 0; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd;
        logic er;
        bit got;
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R9 strobes high in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && cmd_ready && !rsp_valid, "R9 idle outputs in reset", {mem_dq_oe, cmd_ready, rsp_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && mem_we_n, "R1 idle ready", cmd_ready, 1);

        // Vector table walk (R5 R6 R7 R8)
        for (int v = 0; v < NV; v++) begin
            busy_len = int'(VECS[v].busy);
            launch(VECS[v].wr, VECS[v].poll, VECS[v].addr, VECS[v].data);
            wait_rsp(rd, er, got);
            chk(got, "R5 R6 R8 response seen", got, 1);
            if (VECS[v].wr) begin
                if (VECS[v].poll)
                    chk(er == VECS[v].err, "R5 R7 poll write status", er, VECS[v].err);
                else
                    chk(er == VECS[v].err, "R6 R7 ready write status", er, VECS[v].err);
            end else begin
                chk(rd == VECS[v].data && !er, "R8 read data", rd, VECS[v].data);
            end
            wait_idle_mem();
        end

        // R7 boundary: ready seen in the final wait cycle succeeds
        force_en = 1'b1; force_val = 1'b0; busy_len = 0;
        launch(1'b1, 1'b0, 11'h200, 8'h11);
        while (mem_we_n) @(negedge clk);
        while (!mem_we_n) @(negedge clk);
        repeat (H_RDY + TO_C - 3) @(negedge clk);
        force_val = 1'b1;
        repeat (2) @(negedge clk);
        chk(!rsp_valid, "R7 no response before last wait cycle", rsp_valid, 0);
        @(negedge clk);
        chk(rsp_valid && !rsp_error, "R7 R6 ready in last cycle wins", {rsp_valid, rsp_error}, 2);
        @(negedge clk);

        // R7 boundary: ready one cycle late gives the error
        force_val = 1'b0;
        repeat (4) @(negedge clk);
        launch(1'b1, 1'b0, 11'h201, 8'h22);
        while (mem_we_n) @(negedge clk);
        while (!mem_we_n) @(negedge clk);
        repeat (H_RDY + TO_C - 2) @(negedge clk);
        force_val = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R7 no early response", rsp_valid, 0);
        @(negedge clk);
        chk(rsp_valid && rsp_error, "R7 timeout error flag", {rsp_valid, rsp_error}, 3);
        force_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_ready && mem_ce_n && mem_oe_n, "R1 idle after response", cmd_ready, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule